// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block sets the division applied on the feedback path of a fractional-N frequency synthesizer. It receives a pulse stream from the divided oscillator path, which is assumed to be already synchronous to the system clock. It emits one output pulse for every D input pulses. The divisor D for each output cycle is either the integer count N or N+1. A first-order phase accumulator makes that choice, so the long-run ratio is N + F/M. F is the fractional numerator and M is the modulus.

The configuration has several parts: the integer count, the numerator, the modulus, an integer-mode select, an enable that turns a zero numerator into integer operation, and a hold control that keeps the counter in reset. The block checks the configuration against the legal ranges for the mode it would produce. A setting that fails this check raises an error flag, and the last legal setting stays in force. New settings are sampled only while held, or at the end of an output cycle. The block reports the effective mode and the divisor that applies to the current cycle.

Top module: `fracn_div_ctrl`

## Requirements
- R1: Synchronous reset (rst=1 at a clock edge) sets div_pulse=0, eff_int=1, cfg_err=0, and div_val=16. This default is integer mode with N=16.
- R2: While cfg_hold=1, the count is cleared and div_pulse stays 0 whatever vco_tick does. The configuration is sampled on every held clock, the accumulator is cleared, and the first cycle after release divides by the sampled N.
- R3: In effective integer mode, every output cycle is exactly N vco_tick pulses long. div_pulse rises on the clock after the Nth tick and lasts one clock.
- R4: The effective mode is integer when cfg_int_sel=1, or when cfg_int_sel=0 with cfg_auto_int=1 and cfg_f=0. With cfg_f=0 and cfg_auto_int=0, the mode stays fractional (eff_int=0) and every cycle divides by N.
- R5: In fractional mode, each output-cycle boundary adds F to the accumulator. If the sum is at least M, M is subtracted and the next cycle divides by N+1. Otherwise the next cycle divides by N. Any M consecutive cycles therefore contain exactly F cycles of N+1. A change of M clears the accumulator.
- R6: In integer mode, N is legal from 16 to 65535. Any N below 16 is rejected.
- R7: In fractional mode, the setting is legal only when N is in 19..4091, M is at least 2, and F < M.
- R8: An illegal sampled setting sets cfg_err=1 and leaves the previous legal N, F, M and mode in force. The next legal sample clears cfg_err and applies the new setting.
- R9: Configuration changes made while cfg_hold=0 take effect only at the next output-cycle boundary. The cycle in progress keeps its divisor.
- R10: div_val always shows the divisor of the cycle in progress. In integer mode it equals N, and the accumulator stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_n | input | 16 | Integer divide count N |
| cfg_f | input | 12 | Fractional numerator F |
| cfg_m | input | 12 | Fractional modulus M |
| cfg_int_sel | input | 1 | 1 forces integer mode |
| cfg_auto_int | input | 1 | 1 selects integer mode when F is zero |
| cfg_hold | input | 1 | 1 holds the divide counter in reset |
| vco_tick | input | 1 | One-clock pulse per divided oscillator edge |
| div_pulse | output | 1 | One-clock pulse at the end of each output cycle |
| div_val | output | 16 | Divisor of the cycle in progress |
| eff_int | output | 1 | 1 when the effective mode is integer |
| cfg_err | output | 1 | 1 when the last sampled setting was illegal |

## Verification
The bench builds the block with its default parameters: a 16-bit integer count, a 12-bit modulus, and the legal limits 16, 19, 4091 and 2. Small values of N keep cycles short, so long runs of output cycles can be counted tick by tick. With these limits the bench can check both edges of the fractional N range, including one full cycle at N=4091. It can also run a modulus of 4095 with a numerator of 4094. The largest integer count is checked through the error flag and div_val rather than by running a full cycle.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  parameter int unsigned NW = 16;
  parameter int unsigned MW = 12;

  typedef struct packed {
    logic [NW-1:0] n;
    logic [MW-1:0] f;
    logic [MW-1:0] m;
    logic          int_mode;
  } fdiv_cfg_t;
endpackage

// File: rtl/fracn_cfg_gate.sv
module fracn_cfg_gate
  import fracn_pkg::*;
#(
  parameter int unsigned N_INT_MIN  = 16,
  parameter int unsigned N_FRAC_MIN = 19,
  parameter int unsigned N_FRAC_MAX = 4091,
  parameter int unsigned M_MIN      = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [NW-1:0] in_n,
  input  logic [MW-1:0] in_f,
  input  logic [MW-1:0] in_m,
  input  logic          in_isel,
  input  logic          in_auto,
  output fdiv_cfg_t     sel,
  output fdiv_cfg_t     act,
  output logic          err
);
  logic      want_int;
  logic      legal;
  fdiv_cfg_t cand;

  always_comb begin
    want_int = in_isel || (in_auto && (in_f == '0));
    cand     = '{n: in_n, f: in_f, m: in_m, int_mode: want_int};
    if (want_int)
      legal = (in_n >= NW'(N_INT_MIN));
    else
      legal = (in_n >= NW'(N_FRAC_MIN)) && (in_n <= NW'(N_FRAC_MAX)) &&
              (in_m >= MW'(M_MIN)) && (in_f < in_m);
    sel = legal ? cand : act;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= '{n: NW'(N_INT_MIN), f: '0, m: MW'(M_MIN), int_mode: 1'b1};
      err <= 1'b0;
    end else if (load) begin
      if (legal) act <= cand;
      err <= !legal;
    end
  end

  // R8: a rejected sample leaves the active setting untouched
  p_keep_on_err_r8: assert property (@(posedge clk) disable iff (rst)
    (load && !legal) |=> (act == $past(act)));

  // R7: an active fractional setting is always inside the fractional range
  p_frac_legal_r7: assert property (@(posedge clk) disable iff (rst)
    !act.int_mode |-> (act.n >= NW'(N_FRAC_MIN) && act.n <= NW'(N_FRAC_MAX) &&
                       act.m >= MW'(M_MIN) && act.f < act.m));

  // R6: an active integer setting never has N below the integer minimum
  p_int_legal_r6: assert property (@(posedge clk) disable iff (rst)
    act.int_mode |-> (act.n >= NW'(N_INT_MIN)));
endmodule

// File: rtl/fracn_phase_acc.sv
module fracn_phase_acc
  import fracn_pkg::*;
#(
  parameter int unsigned N_INT_MIN = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          hold,
  input  fdiv_cfg_t     sel,
  input  logic [NW-1:0] act_n,
  input  logic [MW-1:0] act_m,
  input  logic          act_int,
  output logic [NW-1:0] cur_div
);
  localparam int unsigned SW = MW + 1;

  logic [MW-1:0] acc_q;
  logic [MW-1:0] base;
  logic [SW-1:0] sum;
  logic [SW-1:0] diff;
  logic          clr;
  logic          carry;

  always_comb begin
    clr   = hold || sel.int_mode;
    base  = (clr || (sel.m != act_m)) ? '0 : acc_q;
    sum   = {1'b0, base} + {1'b0, sel.f};
    diff  = sum - {1'b0, sel.m};
    carry = !clr && (sum >= {1'b0, sel.m});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      cur_div <= NW'(N_INT_MIN);
    end else if (load) begin
      if (clr)        acc_q <= '0;
      else if (carry) acc_q <= diff[MW-1:0];
      else            acc_q <= sum[MW-1:0];
      cur_div <= sel.n + NW'(carry);
    end
  end

  // R5: the stored phase stays below the active modulus
  p_acc_bound_r5: assert property (@(posedge clk) disable iff (rst)
    !act_int |-> (acc_q < act_m));

  // R5: a fractional cycle divides by N or N+1 only
  p_div_step_r5: assert property (@(posedge clk) disable iff (rst)
    !act_int |-> (cur_div == act_n || cur_div == act_n + NW'(1)));

  // R10: integer operation keeps the phase at zero and the divisor at N
  p_int_zero_r10: assert property (@(posedge clk) disable iff (rst)
    act_int |-> (acc_q == '0 && cur_div == act_n));
endmodule

// File: rtl/fracn_pulse_cnt.sv
module fracn_pulse_cnt
  import fracn_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          tick,
  input  logic [NW-1:0] cur_div,
  output logic          bnd,
  output logic          div_pulse
);
  logic [NW-1:0] cnt;
  logic          last;

  always_comb begin
    last = (cnt == cur_div - NW'(1));
    bnd  = tick && !hold && last;
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt       <= '0;
      div_pulse <= 1'b0;
    end else begin
      div_pulse <= bnd;
      if (tick) cnt <= last ? '0 : cnt + NW'(1);
    end
  end

  // R2: no output pulse follows a held clock
  p_hold_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    hold |=> !div_pulse);

  // R3: the count never reaches the divisor of the cycle in progress
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    cnt < cur_div);

  // R3: an output pulse lasts one clock
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);
endmodule

// File: rtl/fracn_div_ctrl.sv
module fracn_div_ctrl
  import fracn_pkg::*;
#(
  parameter int unsigned N_INT_MIN  = 16,
  parameter int unsigned N_FRAC_MIN = 19,
  parameter int unsigned N_FRAC_MAX = 4091,
  parameter int unsigned M_MIN      = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] cfg_n,
  input  logic [MW-1:0] cfg_f,
  input  logic [MW-1:0] cfg_m,
  input  logic          cfg_int_sel,
  input  logic          cfg_auto_int,
  input  logic          cfg_hold,
  input  logic          vco_tick,
  output logic          div_pulse,
  output logic [NW-1:0] div_val,
  output logic          eff_int,
  output logic          cfg_err
);
  fdiv_cfg_t     sel;
  fdiv_cfg_t     act;
  logic          bnd;
  logic          load;
  logic [NW-1:0] cur_div;

  assign load    = bnd || cfg_hold;
  assign div_val = cur_div;
  assign eff_int = act.int_mode;

  fracn_cfg_gate #(
    .N_INT_MIN (N_INT_MIN),
    .N_FRAC_MIN(N_FRAC_MIN),
    .N_FRAC_MAX(N_FRAC_MAX),
    .M_MIN     (M_MIN)
  ) u_gate (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .in_n   (cfg_n),
    .in_f   (cfg_f),
    .in_m   (cfg_m),
    .in_isel(cfg_int_sel),
    .in_auto(cfg_auto_int),
    .sel    (sel),
    .act    (act),
    .err    (cfg_err)
  );

  fracn_phase_acc #(
    .N_INT_MIN(N_INT_MIN)
  ) u_acc (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .hold   (cfg_hold),
    .sel    (sel),
    .act_n  (act.n),
    .act_m  (act.m),
    .act_int(act.int_mode),
    .cur_div(cur_div)
  );

  fracn_pulse_cnt u_cnt (
    .clk      (clk),
    .rst      (rst),
    .hold     (cfg_hold),
    .tick     (vco_tick),
    .cur_div  (cur_div),
    .bnd      (bnd),
    .div_pulse(div_pulse)
  );

  // R9: with the counter running, a cycle's divisor changes only at its boundary
  p_div_at_bnd_r9: assert property (@(posedge clk) disable iff (rst)
    (!cfg_hold && !bnd) |=> $stable(div_val));
endmodule

// File: tb/fracn_div_ctrl_bench.sv
module fracn_div_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NV         = 14;

  typedef struct packed {
    logic [15:0] n;
    logic [11:0] f;
    logic [11:0] m;
    logic        isel;
    logic        auto_i;
    logic        exp_int;
    logic        exp_err;
    logic [7:0]  ncyc;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{16'd20,   12'd0,    12'd4,    1'b1, 1'b0, 1'b1, 1'b0, 8'd3},  // R3
    '{16'd20,   12'd3,    12'd7,    1'b0, 1'b0, 1'b0, 1'b0, 8'd15}, // R5
    '{16'd19,   12'd0,    12'd5,    1'b0, 1'b1, 1'b1, 1'b0, 8'd3},  // R4 auto
    '{16'd19,   12'd0,    12'd5,    1'b0, 1'b0, 1'b0, 1'b0, 8'd4},  // R4 stay frac
    '{16'd18,   12'd1,    12'd3,    1'b0, 1'b0, 1'b0, 1'b1, 8'd2},  // R7 N low
    '{16'd18,   12'd0,    12'd0,    1'b1, 1'b0, 1'b1, 1'b0, 8'd2},  // R6 int N ok
    '{16'd15,   12'd0,    12'd0,    1'b1, 1'b0, 1'b1, 1'b1, 8'd2},  // R6 int N low
    '{16'd30,   12'd5,    12'd5,    1'b0, 1'b0, 1'b1, 1'b1, 8'd2},  // R7 F>=M
    '{16'd30,   12'd1,    12'd1,    1'b0, 1'b0, 1'b1, 1'b1, 8'd1},  // R7 M<2
    '{16'd4092, 12'd1,    12'd3,    1'b0, 1'b0, 1'b1, 1'b1, 8'd1},  // R7 N high
    '{16'd4091, 12'd1,    12'd3,    1'b0, 1'b0, 1'b0, 1'b0, 8'd1},  // R7/R8 edge, clears err
    '{16'd25,   12'd4094, 12'd4095, 1'b0, 1'b0, 1'b0, 1'b0, 8'd6},  // R5 big M
    '{16'd24,   12'd2,    12'd3,    1'b0, 1'b1, 1'b0, 1'b0, 8'd9},  // R5/R4 auto, F>0
    '{16'd65535,12'd0,    12'd0,    1'b1, 1'b0, 1'b1, 1'b0, 8'd0}   // R6 int N max
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg_n = 16'd0;
  logic [11:0] cfg_f = 12'd0;
  logic [11:0] cfg_m = 12'd0;
  logic        cfg_int_sel = 1'b0;
  logic        cfg_auto_int = 1'b0;
  logic        cfg_hold = 1'b0;
  logic        vco_tick = 1'b0;
  logic        div_pulse;
  logic [15:0] div_val;
  logic        eff_int;
  logic        cfg_err;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  int kn = 16, kf = 0, km = 2;
  bit kint = 1'b1;
  int acc = 0, cur = 16;

  always #(CLK_PERIOD/2) clk = ~clk;

  fracn_div_ctrl u_fracn_div_ctrl (
    .clk(clk), .rst(rst), .cfg_n(cfg_n), .cfg_f(cfg_f), .cfg_m(cfg_m),
    .cfg_int_sel(cfg_int_sel), .cfg_auto_int(cfg_auto_int), .cfg_hold(cfg_hold),
    .vco_tick(vco_tick), .div_pulse(div_pulse), .div_val(div_val),
    .eff_int(eff_int), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input int got, input int exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      nfail++;
      $display("FAIL watchdog: got %0d cycles expected at most %0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  // one tick; returns the output pulse seen after it
  task automatic tick_once(output bit got);
    @(negedge clk) vco_tick = 1'b1;
    @(negedge clk) vco_tick = 1'b0;
    got = div_pulse;
  endtask

  task automatic measure(output int len);
    bit got;
    len = 0;
    got = 1'b0;
    while (!got && len < 70000) begin
      tick_once(got);
      len++;
    end
  endtask

  task automatic drive_cfg(input int n, input int f, input int m,
                           input bit isel, input bit au);
    cfg_n = 16'(n); cfg_f = 12'(f); cfg_m = 12'(m);
    cfg_int_sel = isel; cfg_auto_int = au;
  endtask

  task automatic held_load;
    @(negedge clk) cfg_hold = 1'b1;
    @(negedge clk);
    @(negedge clk) cfg_hold = 1'b0;
  endtask

  // model step at an output-cycle boundary with the kept setting
  task automatic model_step(output bit longc);
    int sum;
    longc = 1'b0;
    if (kint) begin
      acc = 0; cur = kn;
    end else begin
      sum = acc + kf;
      if (sum >= km) begin acc = sum - km; cur = kn + 1; longc = 1'b1; end
      else begin acc = sum; cur = kn; end
    end
  endtask

  initial begin
    int len;
    bit got;
    bit longc;
    int seen;
    int longs;

    repeat (3) @(negedge clk);
    check("R1 div_pulse", int'(div_pulse), 0);
    check("R1 eff_int", int'(eff_int), 1);
    check("R1 cfg_err", int'(cfg_err), 0);
    check("R1 div_val", int'(div_val), 16);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      drive_cfg(int'(VECS[v].n), int'(VECS[v].f), int'(VECS[v].m),
                VECS[v].isel, VECS[v].auto_i);
      held_load();
      if (!VECS[v].exp_err) begin
        kn = int'(VECS[v].n); kf = int'(VECS[v].f); km = int'(VECS[v].m);
        kint = VECS[v].exp_int;
      end
      acc = 0; cur = kn;
      check($sformatf("R4 eff_int vec %0d", v), int'(eff_int), int'(VECS[v].exp_int));
      check($sformatf("R8 cfg_err vec %0d", v), int'(cfg_err), int'(VECS[v].exp_err));
      check($sformatf("R2 first div_val vec %0d", v), int'(div_val), kn);
      longs = 0;
      for (int c = 0; c < int'(VECS[v].ncyc); c++) begin
        measure(len);
        check($sformatf("R3/R5 cycle %0d length vec %0d", c, v), len, cur);
        model_step(longc);
        if (c < km) longs += int'(longc);
        check($sformatf("R10 div_val after cycle %0d vec %0d", c, v), int'(div_val), cur);
      end
      if (!kint && int'(VECS[v].ncyc) >= km + 1)
        check($sformatf("R5 long cycles per M vec %0d", v), longs, kf);
    end

    // R2: ticks while held give no pulse; a mid-cycle hold restarts the count
    drive_cfg(16, 0, 2, 1'b1, 1'b0);
    held_load();
    @(negedge clk) cfg_hold = 1'b1;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      tick_once(got);
      seen += int'(got);
    end
    check("R2 pulses while held", seen, 0);
    @(negedge clk) cfg_hold = 1'b0;
    for (int i = 0; i < 7; i++) tick_once(got);
    @(negedge clk) cfg_hold = 1'b1;
    @(negedge clk) cfg_hold = 1'b0;
    measure(len);
    check("R2 length after mid-cycle hold", len, 16);

    // R9: a change mid-cycle waits for the boundary
    drive_cfg(20, 0, 2, 1'b1, 1'b0);
    held_load();
    for (int i = 0; i < 5; i++) tick_once(got);
    drive_cfg(30, 0, 2, 1'b1, 1'b0);
    check("R9 div_val before boundary", int'(div_val), 20);
    measure(len);
    check("R9 cycle keeps old divisor", len + 5, 20);
    check("R9 div_val after boundary", int'(div_val), 30);
    measure(len);
    check("R9 next cycle uses new divisor", len, 30);

    // R8: illegal change at a boundary is rejected, legal one clears the flag
    drive_cfg(10, 0, 2, 1'b1, 1'b0);
    measure(len);
    check("R8 err after illegal boundary sample", int'(cfg_err), 1);
    check("R8 kept divisor", int'(div_val), 30);
    drive_cfg(17, 0, 2, 1'b1, 1'b0);
    measure(len);
    check("R8 cycle with kept divisor", len, 30);
    check("R8 err cleared", int'(cfg_err), 0);
    check("R8 new divisor applied", int'(div_val), 17);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule